// File: doc/BRIEF.md
# Debug Link Bring-Up Sequencer

This controller brings a two-wire serial debug link from an unknown state to a usable memory access port. After a `start` pulse it walks a fixed script. It issues a line reset and then the pattern that switches the target from JTAG to the two-wire protocol. A second line reset follows, and then five register transactions run in order. The first reads and verifies the debug port identification word. The second selects access port 0 and bank 0. The third raises the debug and system power-up requests. The fourth polls the status register until both power-up acknowledge bits are set. The last configures the memory access port for 32-bit, auto-incrementing, enabled transfers.

The sequencer does not move bits on the wire itself. It sits above a wire engine and hands that engine two kinds of work. A raw request is a bit pattern and a length, sent LSB first. A transaction request is an 8-bit header and a 32-bit write word. The engine answers each request with a one-cycle done pulse. For a transaction, the done pulse comes with the 3-bit acknowledge and the read word.

The sequencer handles every response the target can give. A WAIT response makes it reissue the same transaction. A FAULT response stops the run with an error that names the step. An unexpected acknowledge restarts the script from the first line reset. When the run ends, the block holds `done`, or `err` with a category code and the failing step, until the next start.

Top module: `dlink_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `raw_req` and `txn_req` are all low, and no request is issued while `busy` is low.
- R2: A line reset is a raw request with `raw_len` = 52. Bits 0..49 of `raw_bits` are 1 and every higher bit is 0, which gives 50 high clocks followed by 2 idle clocks. It is the first request of every run and is issued again right after the switch pattern.
- R3: The switch pattern is a raw request with `raw_bits` = 0xE79E and `raw_len` = 16. It is issued between the two line resets.
- R4: A transaction header is sent bit 7 first. From bit 7 down, its bits are start=1, port select, read flag, A2, A3, parity of those four, stop=0 and park=1. The transactions are issued in this order: 0xA5 (ID read), 0x8D with write word 0, 0x95 with write word 0x50000000, 0xB1 (status read) and 0xC5 with write word 0x23000052.
- R5: If the ID read returns any value other than 0x2BA01477, the run ends with `err_code` 1 and `err_step` 3, and no further request is issued.
- R6: The status read is repeated until its read word has both bit 29 and bit 31 set. If `poll_limit` reads in a row fail this test, the run ends with `err_code` 4 and `err_step` 6. A `poll_limit` of 0 acts as 1.
- R7: Acknowledge bit 0 is the first bit on the wire: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. A WAIT reissues the identical transaction, up to 4 times in a row. A fifth WAIT in a row ends the run with `err_code` 3 and the current step.
- R8: A FAULT ends the run at once with `err_code` 2, and `err_step` names the step. Steps are numbered 0 (first reset), 1 (switch), 2 (second reset), 3 (ID read), 4 (select), 5 (power request), 6 (status poll) and 7 (port configuration).
- R9: Any other acknowledge restarts the script from the first line reset. After 3 such restarts, a fourth one ends the run with `err_code` 5 and the current step.
- R10: An OK on the port configuration write sets `done` and clears `busy`. `done` and `err` never show together, and each holds until the next accepted start, which clears both.
- R11: A `start` pulse while `busy` is high has no effect on the request sequence.
- R12: Requests are single-cycle pulses, at most one kind at a time. No new request is issued until the engine has returned done for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin bring-up (accepted only when idle) |
| poll_limit | input | 16 | Maximum number of failed power-acknowledge reads |
| raw_req | output | 1 | Raw bit-pattern request pulse |
| raw_bits | output | 64 | Raw pattern, LSB sent first |
| raw_len | output | 7 | Number of raw bits to send |
| raw_done | input | 1 | Engine finished the raw request |
| txn_req | output | 1 | Transaction request pulse |
| txn_hdr | output | 8 | Transaction header, bit 7 first on wire |
| txn_wdata | output | 32 | Write word for write transactions |
| txn_done | input | 1 | Engine finished the transaction |
| txn_ack | input | 3 | Acknowledge, bit 0 first on wire |
| txn_rdata | input | 32 | Read word |
| busy | output | 1 | Sequence running |
| done | output | 1 | Bring-up completed |
| err | output | 1 | Bring-up failed |
| err_code | output | 3 | Failure category |
| err_step | output | 3 | Step in which the failure occurred |

## Verification
A wrong step register shows up on the very next request pulse: the header, write word or raw pattern leaves the expected order, and the scoreboard catches this at the transaction where the order breaks. A wrong retry or poll counter shows up as one request too many or one too few before `err` rises. A run that ends too early or too late leaves queue entries unconsumed, or triggers a request that has no matching entry. A flaw in the outcome registers shows up as a wrong `err_code`/`err_step` pair, or as a stale `done` or `err`, at the first idle cycle after the final done pulse.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    typedef enum logic [2:0] {
        ST_RST1    = 3'd0,
        ST_SWITCH  = 3'd1,
        ST_RST2    = 3'd2,
        ST_IDREAD  = 3'd3,
        ST_SELECT  = 3'd4,
        ST_PWRREQ  = 3'd5,
        ST_PWRPOLL = 3'd6,
        ST_CSWCFG  = 3'd7
    } step_e;

    typedef enum logic [2:0] {
        EC_NONE    = 3'd0,
        EC_IDMISS  = 3'd1,
        EC_FAULT   = 3'd2,
        EC_WAITLIM = 3'd3,
        EC_POLLTO  = 3'd4,
        EC_PROTO   = 3'd5
    } ecode_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    // header byte, bit 7 leaves first: start, port, read, A2, A3, parity, stop, park
    function automatic logic [7:0] make_hdr(input logic port, input logic rd,
                                            input logic [1:0] a);
        logic par;
        par = port ^ rd ^ a[0] ^ a[1];
        return {1'b1, port, rd, a[0], a[1], par, 1'b0, 1'b1};
    endfunction

endpackage

// File: rtl/dlink_step_cmd.sv
module dlink_step_cmd
    import dlink_pkg::*;
#(
    parameter int          RAW_W      = 64,
    parameter int          RESET_LEN  = 50,
    parameter int          IDLE_LEN   = 2,
    parameter logic [15:0] SWITCH_SEQ = 16'hE79E,
    parameter logic [31:0] PWR_WORD   = 32'h5000_0000,
    parameter logic [31:0] CSW_WORD   = 32'h2300_0052,
    localparam int         LEN_W      = $clog2(RAW_W + 1)
) (
    input  step_e              step,
    output logic               is_raw,
    output logic [RAW_W-1:0]   raw_bits,
    output logic [LEN_W-1:0]   raw_len,
    output logic [7:0]         hdr,
    output logic [31:0]        wdata
);
    localparam int SW_LEN = 16;

    logic [RAW_W-1:0] rst_mask;
    logic [RAW_W-1:0] sw_bits;

    // constant line-reset pattern: high for RESET_LEN bits, low after
    for (genvar i = 0; i < RAW_W; i++) begin : g_mask
        assign rst_mask[i] = (i < RESET_LEN);
    end
    assign sw_bits = {{(RAW_W-SW_LEN){1'b0}}, SWITCH_SEQ};

    always_comb begin
        is_raw   = 1'b0;
        raw_bits = rst_mask;
        raw_len  = LEN_W'(RESET_LEN + IDLE_LEN);
        hdr      = 8'h00;
        wdata    = 32'h0;
        case (step)
            ST_RST1, ST_RST2: is_raw = 1'b1;
            ST_SWITCH: begin
                is_raw   = 1'b1;
                raw_bits = sw_bits;
                raw_len  = LEN_W'(SW_LEN);
            end
            ST_IDREAD:  hdr = make_hdr(1'b0, 1'b1, 2'd0);
            ST_SELECT:  hdr = make_hdr(1'b0, 1'b0, 2'd2);
            ST_PWRREQ: begin
                hdr   = make_hdr(1'b0, 1'b0, 2'd1);
                wdata = PWR_WORD;
            end
            ST_PWRPOLL: hdr = make_hdr(1'b0, 1'b1, 2'd1);
            ST_CSWCFG: begin
                hdr   = make_hdr(1'b1, 1'b0, 2'd0);
                wdata = CSW_WORD;
            end
            default: is_raw = 1'b0;
        endcase
    end

endmodule

// File: rtl/dlink_resp_eval.sv
module dlink_resp_eval
    import dlink_pkg::*;
#(
    parameter logic [31:0] EXPECT_ID = 32'h2BA0_1477,
    parameter logic [31:0] PWR_MASK  = 32'hA000_0000
) (
    input  logic [2:0]  ack,
    input  logic [31:0] rdata,
    output logic        ack_ok,
    output logic        ack_wait,
    output logic        ack_fault,
    output logic        ack_bad,
    output logic        id_ok,
    output logic        pwr_ok
);
    always_comb begin
        ack_ok    = (ack == ACK_OK);
        ack_wait  = (ack == ACK_WAIT);
        ack_fault = (ack == ACK_FAULT);
        ack_bad   = !(ack_ok || ack_wait || ack_fault);
        id_ok     = (rdata == EXPECT_ID);
        pwr_ok    = ((rdata & PWR_MASK) == PWR_MASK);
    end

endmodule

// File: rtl/dlink_init_seq.sv
module dlink_init_seq
    import dlink_pkg::*;
#(
    parameter int          RAW_W       = 64,
    parameter int          RESET_LEN   = 50,
    parameter int          IDLE_LEN    = 2,
    parameter int          POLL_W      = 16,
    parameter int          WAIT_LIMIT  = 4,
    parameter int          PROTO_LIMIT = 3,
    parameter logic [31:0] EXPECT_ID   = 32'h2BA0_1477,
    localparam int         LEN_W       = $clog2(RAW_W + 1),
    localparam int         WAIT_W      = $clog2(WAIT_LIMIT + 1),
    localparam int         PERR_W      = $clog2(PROTO_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              raw_req,
    output logic [RAW_W-1:0]  raw_bits,
    output logic [LEN_W-1:0]  raw_len,
    input  logic              raw_done,
    output logic              txn_req,
    output logic [7:0]        txn_hdr,
    output logic [31:0]       txn_wdata,
    input  logic              txn_done,
    input  logic [2:0]        txn_ack,
    input  logic [31:0]       txn_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [2:0]        err_step
);
    typedef struct packed {
        logic              run;
        logic              await;
        logic              done;
        logic              err;
        ecode_e            code;
        step_e             estep;
        step_e             step;
        logic [WAIT_W-1:0] wcnt;
        logic [POLL_W-1:0] pcnt;
        logic [PERR_W-1:0] ecnt;
    } seq_s;

    seq_s q, d;

    logic        is_raw;
    logic        ack_ok, ack_wait, ack_fault, ack_bad, id_ok, pwr_ok;
    logic [POLL_W:0] poll_next;
    logic        poll_over;

    dlink_step_cmd #(
        .RAW_W     (RAW_W),
        .RESET_LEN (RESET_LEN),
        .IDLE_LEN  (IDLE_LEN)
    ) i_cmd (
        .step     (q.step),
        .is_raw   (is_raw),
        .raw_bits (raw_bits),
        .raw_len  (raw_len),
        .hdr      (txn_hdr),
        .wdata    (txn_wdata)
    );

    dlink_resp_eval #(
        .EXPECT_ID (EXPECT_ID)
    ) i_eval (
        .ack       (txn_ack),
        .rdata     (txn_rdata),
        .ack_ok    (ack_ok),
        .ack_wait  (ack_wait),
        .ack_fault (ack_fault),
        .ack_bad   (ack_bad),
        .id_ok     (id_ok),
        .pwr_ok    (pwr_ok)
    );

    assign poll_next = {1'b0, q.pcnt} + 1'b1;
    assign poll_over = (poll_next >= {1'b0, poll_limit});

    always_comb begin
        logic   fail;
        ecode_e fcode;
        d     = q;
        fail  = 1'b0;
        fcode = EC_NONE;
        if (start && !q.run) begin
            d      = '0;
            d.run  = 1'b1;
            d.step = ST_RST1;
        end else if (q.run) begin
            if (!q.await) begin
                d.await = 1'b1;
            end else if (is_raw && raw_done) begin
                d.await = 1'b0;
                d.step  = step_e'(q.step + 3'd1);
            end else if (!is_raw && txn_done) begin
                d.await = 1'b0;
                if (ack_ok) begin
                    d.wcnt = '0;
                    case (q.step)
                        ST_IDREAD: begin
                            if (id_ok) d.step = ST_SELECT;
                            else begin fail = 1'b1; fcode = EC_IDMISS; end
                        end
                        ST_PWRPOLL: begin
                            if (pwr_ok) d.step = ST_CSWCFG;
                            else if (poll_over) begin fail = 1'b1; fcode = EC_POLLTO; end
                            else d.pcnt = q.pcnt + 1'b1;
                        end
                        ST_CSWCFG: begin
                            d.run  = 1'b0;
                            d.done = 1'b1;
                        end
                        default: d.step = step_e'(q.step + 3'd1);
                    endcase
                end else if (ack_wait) begin
                    if (q.wcnt == WAIT_W'(WAIT_LIMIT)) begin
                        fail = 1'b1; fcode = EC_WAITLIM;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end else if (ack_fault) begin
                    fail = 1'b1; fcode = EC_FAULT;
                end else if (ack_bad) begin
                    if (q.ecnt == PERR_W'(PROTO_LIMIT)) begin
                        fail = 1'b1; fcode = EC_PROTO;
                    end else begin
                        d.ecnt = q.ecnt + 1'b1;
                        d.step = ST_RST1;
                        d.wcnt = '0;
                        d.pcnt = '0;
                    end
                end
            end
        end
        if (fail) begin
            d.run   = 1'b0;
            d.err   = 1'b1;
            d.code  = fcode;
            d.estep = q.step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw_req  = q.run && !q.await && is_raw;
    assign txn_req  = q.run && !q.await && !is_raw;
    assign busy     = q.run;
    assign done     = q.done;
    assign err      = q.err;
    assign err_code = q.code;
    assign err_step = q.estep;

endmodule

// File: rtl/dlink_init_chk.sv
module dlink_init_chk #(
    parameter int          RAW_W     = 64,
    parameter int          RESET_LEN = 50,
    parameter int          IDLE_LEN  = 2,
    parameter logic [31:0] EXPECT_ID = 32'h2BA0_1477,
    localparam int         LEN_W     = $clog2(RAW_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [2:0]       err_code,
    input logic             raw_req,
    input logic             txn_req,
    input logic [RAW_W-1:0] raw_bits,
    input logic [LEN_W-1:0] raw_len,
    input logic             txn_done,
    input logic [2:0]       txn_ack,
    input logic [31:0]      txn_rdata
);
    localparam logic [RAW_W-1:0] RST_PAT = (RAW_W'(1) << RESET_LEN) - RAW_W'(1);

    // R12
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({raw_req, txn_req}));

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_req || txn_req) |=> !(raw_req || txn_req));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(raw_req || txn_req));

    // R10
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));

    // R10
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(txn_done) && $past(txn_ack) == 3'b001));

    // R5
    id_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err) && err_code == 3'd1) |-> ($past(txn_rdata) != EXPECT_ID));

    // R2
    rst_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_req && raw_len == LEN_W'(RESET_LEN + IDLE_LEN)) |-> (raw_bits == RST_PAT));

endmodule

bind dlink_init_seq dlink_init_chk #(
    .RAW_W     (RAW_W),
    .RESET_LEN (RESET_LEN),
    .IDLE_LEN  (IDLE_LEN),
    .EXPECT_ID (EXPECT_ID)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .raw_req   (raw_req),
    .txn_req   (txn_req),
    .raw_bits  (raw_bits),
    .raw_len   (raw_len),
    .txn_done  (txn_done),
    .txn_ack   (txn_ack),
    .txn_rdata (txn_rdata)
);

// File: tb/test_dlink_init_seq.sv
module test_dlink_init_seq;

    localparam logic [31:0] ID_OK = 32'h2BA0_1477;
    localparam logic [63:0] RST_BITS = 64'h0003_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] poll_limit = 16'd8;
    logic        raw_req, txn_req;
    logic [63:0] raw_bits;
    logic [6:0]  raw_len;
    logic        raw_done = 1'b0;
    logic [7:0]  txn_hdr;
    logic [31:0] txn_wdata;
    logic        txn_done = 1'b0;
    logic [2:0]  txn_ack = 3'b000;
    logic [31:0] txn_rdata = 32'h0;
    logic        busy, done, err;
    logic [2:0]  err_code, err_step;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dlink_init_seq i_dlink_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
        .raw_req(raw_req), .raw_bits(raw_bits), .raw_len(raw_len), .raw_done(raw_done),
        .txn_req(txn_req), .txn_hdr(txn_hdr), .txn_wdata(txn_wdata),
        .txn_done(txn_done), .txn_ack(txn_ack), .txn_rdata(txn_rdata),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .err_step(err_step)
    );

    typedef struct {
        logic        is_raw;
        logic [63:0] bits;
        logic [6:0]  len;
        logic [7:0]  hdr;
        logic [31:0] wdata;
        logic [2:0]  ack;
        logic [31:0] rdata;
        string       tag;
    } item_t;

    item_t expq[$];

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_raw(input logic [63:0] bits, input logic [6:0] len, input string tag);
        item_t it;
        it.is_raw = 1'b1; it.bits = bits; it.len = len;
        it.hdr = 8'h0; it.wdata = 32'h0; it.ack = 3'b001; it.rdata = 32'h0; it.tag = tag;
        expq.push_back(it);
    endtask

    task automatic push_txn(input logic [7:0] hdr, input logic [31:0] wdata,
                            input logic [2:0] ack, input logic [31:0] rdata, input string tag);
        item_t it;
        it.is_raw = 1'b0; it.bits = 64'h0; it.len = 7'd0;
        it.hdr = hdr; it.wdata = wdata; it.ack = ack; it.rdata = rdata; it.tag = tag;
        expq.push_back(it);
    endtask

    // R2, R3: reset, switch, reset
    task automatic push_prefix();
        push_raw(RST_BITS, 7'd52, "R2");
        push_raw(64'hE79E, 7'd16, "R3");
        push_raw(RST_BITS, 7'd52, "R2");
    endtask

    // engine model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            raw_done = 1'b0;
            txn_done = 1'b0;
            if (raw_req || txn_req) begin
                item_t it;
                if (expq.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R12 unexpected request: actual raw=%0b txn=%0b hdr=%0h expected none",
                             raw_req, txn_req, txn_hdr);
                    it.is_raw = raw_req; it.ack = 3'b001; it.rdata = 32'h0; it.tag = "R12";
                end else begin
                    it = expq.pop_front();
                    check(it.tag, "kind", {63'h0, raw_req}, {63'h0, it.is_raw});
                    if (it.is_raw) begin
                        check(it.tag, "raw_bits", raw_bits, it.bits);
                        check(it.tag, "raw_len", {57'h0, raw_len}, {57'h0, it.len});
                    end else begin
                        check(it.tag, "hdr", {56'h0, txn_hdr}, {56'h0, it.hdr});
                        if (!it.hdr[5])
                            check(it.tag, "wdata", {32'h0, txn_wdata}, {32'h0, it.wdata});
                    end
                end
                repeat (2) @(negedge clk);
                if (it.is_raw) raw_done = 1'b1;
                else begin
                    txn_ack = it.ack; txn_rdata = it.rdata; txn_done = 1'b1;
                end
            end
        end
    end

    task automatic run_case(input string tag, input logic exp_done,
                            input logic [2:0] code, input logic [2:0] step, input bit mid_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
        @(negedge clk);
        check(tag, "busy", {63'h0, busy}, 64'h0);
        check(tag, "done", {63'h0, done}, {63'h0, exp_done});
        check(tag, "err", {63'h0, err}, {63'h0, !exp_done});
        if (!exp_done) begin
            check(tag, "err_code", {61'h0, err_code}, {61'h0, code});
            check(tag, "err_step", {61'h0, err_step}, {61'h0, step});
        end
        check(tag, "items left", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", {63'h0, busy}, 64'h0);
        check("R1", "done", {63'h0, done}, 64'h0);
        check("R1", "err", {63'h0, err}, 64'h0);
        check("R1", "req", {62'h0, raw_req, txn_req}, 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "req after reset", {62'h0, raw_req, txn_req}, 64'h0);

        // R4 R6 R7 R10: full run, one WAIT on select, poll with partial bits
        poll_limit = 16'd8;
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R4");
        push_txn(8'h8D, 32'h0, 3'b010, 32'h0, "R7");
        push_txn(8'h8D, 32'h0, 3'b001, 32'h0, "R7");
        push_txn(8'h95, 32'h5000_0000, 3'b001, 32'h0, "R4");
        push_txn(8'hB1, 32'h0, 3'b001, 32'h8000_0000, "R6");
        push_txn(8'hB1, 32'h0, 3'b001, 32'h2000_0000, "R6");
        push_txn(8'hB1, 32'h0, 3'b001, 32'hA000_0000, "R6");
        push_txn(8'hC5, 32'h2300_0052, 3'b001, 32'h0, "R4");
        run_case("R10", 1'b1, 3'd0, 3'd0, 1'b0);

        // R5: identification mismatch (also clears previous done, R10)
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, 32'h2BA0_1476, "R5");
        run_case("R5", 1'b0, 3'd1, 3'd3, 1'b0);

        // R8: fault on power request
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R8");
        push_txn(8'h8D, 32'h0, 3'b001, 32'h0, "R8");
        push_txn(8'h95, 32'h5000_0000, 3'b100, 32'h0, "R8");
        run_case("R8", 1'b0, 3'd2, 3'd5, 1'b0);

        // R7: five WAITs in a row on port configuration
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R7");
        push_txn(8'h8D, 32'h0, 3'b001, 32'h0, "R7");
        push_txn(8'h95, 32'h5000_0000, 3'b001, 32'h0, "R7");
        push_txn(8'hB1, 32'h0, 3'b001, 32'hA000_0000, "R7");
        for (int w = 0; w < 5; w++) push_txn(8'hC5, 32'h2300_0052, 3'b010, 32'h0, "R7");
        run_case("R7", 1'b0, 3'd3, 3'd7, 1'b0);

        // R6: poll timeout with limit 3
        poll_limit = 16'd3;
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R6");
        push_txn(8'h8D, 32'h0, 3'b001, 32'h0, "R6");
        push_txn(8'h95, 32'h5000_0000, 3'b001, 32'h0, "R6");
        for (int p = 0; p < 3; p++) push_txn(8'hB1, 32'h0, 3'b001, 32'h2000_0000, "R6");
        run_case("R6", 1'b0, 3'd4, 3'd6, 1'b0);
        poll_limit = 16'd8;

        // R9: protocol error restarts, then success; R11: start while busy
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b111, 32'h0, "R9");
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R9");
        push_txn(8'h8D, 32'h0, 3'b000, 32'h0, "R9");
        push_prefix();
        push_txn(8'hA5, 32'h0, 3'b001, ID_OK, "R11");
        push_txn(8'h8D, 32'h0, 3'b001, 32'h0, "R11");
        push_txn(8'h95, 32'h5000_0000, 3'b001, 32'h0, "R11");
        push_txn(8'hB1, 32'h0, 3'b001, 32'hA000_0000, "R11");
        push_txn(8'hC5, 32'h2300_0052, 3'b001, 32'h0, "R11");
        run_case("R11", 1'b1, 3'd0, 3'd0, 1'b1);

        // R9: fourth protocol error ends the run
        for (int r = 0; r < 4; r++) begin
            push_prefix();
            push_txn(8'hA5, 32'h0, 3'b111, 32'h0, "R9");
        end
        run_case("R9", 1'b0, 3'd5, 3'd3, 1'b0);

        summary();
        $finish;
    end

endmodule